// File: doc/BRIEF.md
# Eight-Input Priority Interrupt Controller

This block gathers eight interrupt request lines, holds them in a request register, and picks the most urgent line that is not masked and not shadowed by a line already in service. A host reaches it through a byte-wide port with one address bit. Writes to the even address carry commands. Writes to the odd address carry either the words of the setup sequence or the mask. Reads return the mask, the request or in-service register, or a poll result. The poll result names the winning line and acknowledges it.

A setup sequence starts with a command byte. It can be followed by a vector word, a chaining word and a mode word. The block stores these words and drives them on configuration outputs, so that surrounding logic can chain a second instance behind one input of a first. When the first instance polls as line 2, the host polls the second one and adds 8 to its result. Line 7 doubles as the report for a request that vanished before it was acknowledged. The in-service bit 7 tells that case apart from a real request on line 7.

Top module: `pic_ctrl`

## Requirements
- R1: After reset, the mask, request and in-service registers are all zero and the read register is 0x00. Odd-address reads return 0x00 and even-address reads return the request register. All three configuration outputs are 0x00, `int_out` is low, the block takes setup-free writes (odd writes go to the mask), and it runs in edge mode.
- R2: An even-address write with bit 4 set is a start command. It clears the mask, the in-service and request registers, poll mode and the chaining and mode words, and it selects the request register for readback. Bit 3 of the start command selects level sensing (1) or edge sensing (0). The odd writes that follow fill, in order, the vector word, then the chaining word unless start bit 1 is set, then the mode word only if start bit 0 is set. The next odd write after that loads the mask.
- R3: The chaining word is stored exactly as written and driven on `cfg_cascade`. A master uses it as a line bitmask (0x04) and a slave uses it as its own number (0x02). The vector and mode words appear on `cfg_vector` and `cfg_mode`.
- R4: Once setup is complete, an odd-address write loads the mask, where bit n set masks line n. An odd-address read returns the mask on `bus_rdata` in the cycle after the read strobe. While the setup sequence is running, the mask does not change.
- R5: A line is eligible when its request bit is set, its mask bit is clear, and its index is lower than every set in-service bit. Line 0 has the highest priority. `int_out` is high exactly while some line is eligible.
- R6: An even write of 0x0C arms poll mode (even write with bit 4 clear, bit 3 set, bit 2 = poll). On the next even read, with a line eligible, `bus_rdata` becomes {1, 0000, line} one cycle later, that in-service bit sets and that request bit clears. Poll mode then disarms, and the readback selection is left unchanged.
- R7: A poll read with no eligible line returns 0x07 (bit 7 clear) and leaves the in-service register unchanged.
- R8: An even write with bit 4 clear, bit 3 set and bit 1 set selects the register for later even reads: 0x0B selects in-service and 0x0A selects request. The selection holds until it is rewritten or a start command arrives.
- R9: An even write of 0x20 (bits 7:5 = 001, bits 4:3 = 00) clears the lowest-index set in-service bit. When nothing is in service it has no effect.
- R10: In edge mode a request bit sets on a 0-to-1 change of its line. It clears when the line is low or when that line is acknowledged. A line held high after acknowledge does not request again.
- R11: In level mode the request register copies the lines every cycle, so a line still high after its end-of-interrupt requests again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per byte |
| bus_rd | input | 1 | Read strobe, one cycle per byte |
| bus_addr | input | 1 | 0 = command/status, 1 = setup words/mask |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid the cycle after `bus_rd` |
| irq_in | input | 8 | Interrupt request lines, line 0 most urgent |
| int_out | output | 1 | High while any line is eligible |
| cfg_vector | output | 8 | Stored vector word |
| cfg_cascade | output | 8 | Stored chaining word |
| cfg_mode | output | 8 | Stored mode word |

## Verification
Two functions can land in the same cycle: a poll acknowledge and a non-specific end-of-interrupt. Both use the even address, so a write of 0x20 and a poll read can share one cycle. The acknowledge then sets the new winner's in-service bit while the end-of-interrupt clears the lowest bit that was set before that edge. A directed case arranges this with line 4 in service and line 1 pending, and expects poll data 0x81 and in-service 0x02. The random phase issues the combined strobe often, together with line edges, and compares every read and `int_out` against a bench model built from the requirements.

// File: rtl/pic_pkg.sv
package pic_pkg;
  timeunit 1ns; timeprecision 1ps;

  typedef enum logic [1:0] {
    ST_READY = 2'd0,
    ST_VEC   = 2'd1,
    ST_CAS   = 2'd2,
    ST_MODE  = 2'd3
  } init_st_e;

  // command byte fields at the even address
  localparam int START_BIT   = 4;
  localparam int SELCMD_BIT  = 3;
  localparam int POLL_BIT    = 2;
  localparam int RDSEL_EN    = 1;
  localparam int RDSEL_ISR   = 0;
  localparam int EOI_HI      = 7;
  localparam int EOI_LO      = 5;
  localparam logic [2:0] EOI_NS_CODE = 3'b001;

  // start command option bits
  localparam int LEVEL_BIT   = 3;
  localparam int SINGLE_BIT  = 1;
  localparam int NEED_MODE   = 0;
endpackage

// File: rtl/pic_cmd_decode.sv
module pic_cmd_decode
  import pic_pkg::*;
#(
  parameter int N_IN = 8,
  parameter int DW   = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic            rd_en,
  input  logic            addr,
  input  logic [DW-1:0]   wdata,
  output logic            start_pulse,
  output logic            eoi_pulse,
  output logic            poll_armed,
  output logic            sel_isr,
  output logic            level_mode,
  output logic [N_IN-1:0] imr,
  output logic [DW-1:0]   cfg_vec,
  output logic [DW-1:0]   cfg_cas,
  output logic [DW-1:0]   cfg_mode
);
  timeunit 1ns; timeprecision 1ps;

  init_st_e        state_q, state_d;
  logic [N_IN-1:0] imr_q, imr_d;
  logic            poll_q, poll_d, sel_q, sel_d;
  logic            level_q, level_d, single_q, single_d, need_q, need_d;
  logic [DW-1:0]   vec_q, vec_d, cas_q, cas_d, mode_q, mode_d;
  logic            wr_even, wr_odd, sel_cmd;

  assign wr_even     = wr_en & ~addr;
  assign wr_odd      = wr_en & addr;
  assign start_pulse = wr_even & wdata[START_BIT];
  assign sel_cmd     = wr_even & ~wdata[START_BIT] & wdata[SELCMD_BIT];
  assign eoi_pulse   = wr_even & ~wdata[START_BIT] & ~wdata[SELCMD_BIT]
                     & (wdata[EOI_HI:EOI_LO] == EOI_NS_CODE);

  always_comb begin
    state_d  = state_q;
    imr_d    = imr_q;
    poll_d   = poll_q;
    sel_d    = sel_q;
    level_d  = level_q;
    single_d = single_q;
    need_d   = need_q;
    vec_d    = vec_q;
    cas_d    = cas_q;
    mode_d   = mode_q;
    if (start_pulse) begin
      state_d  = ST_VEC;
      imr_d    = '0;
      poll_d   = 1'b0;
      sel_d    = 1'b0;
      level_d  = wdata[LEVEL_BIT];
      single_d = wdata[SINGLE_BIT];
      need_d   = wdata[NEED_MODE];
      cas_d    = '0;
      mode_d   = '0;
    end else begin
      if (wr_odd) begin
        unique case (state_q)
          ST_VEC: begin
            vec_d   = wdata;
            state_d = single_q ? (need_q ? ST_MODE : ST_READY) : ST_CAS;
          end
          ST_CAS: begin
            cas_d   = wdata;
            state_d = need_q ? ST_MODE : ST_READY;
          end
          ST_MODE: begin
            mode_d  = wdata;
            state_d = ST_READY;
          end
          default: imr_d = wdata[N_IN-1:0];
        endcase
      end
      if (sel_cmd) begin
        poll_d = wdata[POLL_BIT];
        if (wdata[RDSEL_EN]) sel_d = wdata[RDSEL_ISR];
      end else if (rd_en && !addr) begin
        poll_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_READY;
      imr_q    <= '0;
      poll_q   <= 1'b0;
      sel_q    <= 1'b0;
      level_q  <= 1'b0;
      single_q <= 1'b0;
      need_q   <= 1'b0;
      vec_q    <= '0;
      cas_q    <= '0;
      mode_q   <= '0;
    end else begin
      state_q  <= state_d;
      imr_q    <= imr_d;
      poll_q   <= poll_d;
      sel_q    <= sel_d;
      level_q  <= level_d;
      single_q <= single_d;
      need_q   <= need_d;
      vec_q    <= vec_d;
      cas_q    <= cas_d;
      mode_q   <= mode_d;
    end
  end

  assign poll_armed = poll_q;
  assign sel_isr    = sel_q;
  assign level_mode = level_q;
  assign imr        = imr_q;
  assign cfg_vec    = vec_q;
  assign cfg_cas    = cas_q;
  assign cfg_mode   = mode_q;

  a_r2_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |=> (imr_q == '0) && (state_q == ST_VEC) && !poll_q);

  a_r4_mask_frozen_in_setup: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_READY && !start_pulse) |=> $stable(imr_q));
endmodule

// File: rtl/pic_req_latch.sv
module pic_req_latch #(
  parameter int N_IN = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N_IN-1:0] irq_in,
  input  logic            level_mode,
  input  logic            clr_all,
  input  logic [N_IN-1:0] ack_onehot,
  output logic [N_IN-1:0] irr
);
  timeunit 1ns; timeprecision 1ps;

  logic [N_IN-1:0] prev_q, irr_q, irr_d;

  always_comb begin
    if (clr_all)
      irr_d = '0;
    else if (level_mode)
      irr_d = irq_in;
    else
      irr_d = (irr_q | (irq_in & ~prev_q)) & irq_in & ~ack_onehot;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      irr_q  <= '0;
    end else begin
      prev_q <= irq_in;
      irr_q  <= irr_d;
    end
  end

  assign irr = irr_q;

  a_r10_request_needs_line: assert property (@(posedge clk) disable iff (!rst_n)
    (irr_q & ~prev_q) == '0);

  a_r11_level_copies_lines: assert property (@(posedge clk) disable iff (!rst_n)
    (level_mode && !clr_all) |=> irr_q == $past(irq_in));
endmodule

// File: rtl/pic_prio_resolve.sv
module pic_prio_resolve #(
  parameter int N_IN = 8,
  localparam int ID_W = $clog2(N_IN)
) (
  input  logic [N_IN-1:0] irr,
  input  logic [N_IN-1:0] imr,
  input  logic [N_IN-1:0] isr,
  output logic            any_req,
  output logic [ID_W-1:0] pick_id,
  output logic [N_IN-1:0] pick_oh,
  output logic [N_IN-1:0] isr_low_oh
);
  timeunit 1ns; timeprecision 1ps;

  logic [N_IN:0]   shield_c;
  logic [N_IN:0]   seen_c;
  logic [N_IN-1:0] elig;

  assign shield_c[0] = 1'b0;
  assign seen_c[0]   = 1'b0;

  for (genvar i = 0; i < N_IN; i++) begin : g_chain
    assign shield_c[i+1] = shield_c[i] | isr[i];
    assign elig[i]       = irr[i] & ~imr[i] & ~shield_c[i+1];
    assign pick_oh[i]    = elig[i] & ~seen_c[i];
    assign seen_c[i+1]   = seen_c[i] | elig[i];
    assign isr_low_oh[i] = isr[i] & ~shield_c[i];
  end

  assign any_req = seen_c[N_IN];

  always_comb begin
    pick_id = '0;
    for (int i = 0; i < N_IN; i++)
      if (pick_oh[i]) pick_id = pick_id | ID_W'(i);
  end
endmodule

// File: rtl/pic_ctrl.sv
module pic_ctrl
  import pic_pkg::*;
#(
  parameter int N_IN = 8,
  parameter int DW   = 8,
  localparam int ID_W = $clog2(N_IN)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_wr,
  input  logic            bus_rd,
  input  logic            bus_addr,
  input  logic [DW-1:0]   bus_wdata,
  output logic [DW-1:0]   bus_rdata,
  input  logic [N_IN-1:0] irq_in,
  output logic            int_out,
  output logic [DW-1:0]   cfg_vector,
  output logic [DW-1:0]   cfg_cascade,
  output logic [DW-1:0]   cfg_mode
);
  timeunit 1ns; timeprecision 1ps;

  logic            start_pulse, eoi_pulse, poll_armed, sel_isr, level_mode;
  logic [N_IN-1:0] imr, irr, pick_oh, isr_low_oh, ack_oh;
  logic [N_IN-1:0] isr_q, isr_d;
  logic [DW-1:0]   rdata_q, rdata_d;
  logic [ID_W-1:0] pick_id;
  logic            any_req, poll_read, ack;

  pic_cmd_decode #(.N_IN(N_IN), .DW(DW)) u_decode (
    .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .rd_en(bus_rd), .addr(bus_addr),
    .wdata(bus_wdata), .start_pulse(start_pulse), .eoi_pulse(eoi_pulse),
    .poll_armed(poll_armed), .sel_isr(sel_isr), .level_mode(level_mode),
    .imr(imr), .cfg_vec(cfg_vector), .cfg_cas(cfg_cascade), .cfg_mode(cfg_mode)
  );

  pic_req_latch #(.N_IN(N_IN)) u_req (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .level_mode(level_mode),
    .clr_all(start_pulse), .ack_onehot(ack_oh), .irr(irr)
  );

  pic_prio_resolve #(.N_IN(N_IN)) u_prio (
    .irr(irr), .imr(imr), .isr(isr_q), .any_req(any_req), .pick_id(pick_id),
    .pick_oh(pick_oh), .isr_low_oh(isr_low_oh)
  );

  assign poll_read = bus_rd & ~bus_addr & poll_armed;
  assign ack       = poll_read & any_req;
  assign ack_oh    = ack ? pick_oh : '0;

  always_comb begin
    if (start_pulse)
      isr_d = '0;
    else
      isr_d = (isr_q & ~(eoi_pulse ? isr_low_oh : '0)) | ack_oh;
  end

  always_comb begin
    rdata_d = rdata_q;
    if (bus_rd) begin
      if (bus_addr)
        rdata_d = DW'(imr);
      else if (poll_armed)
        rdata_d = any_req ? {1'b1, (DW-1)'(pick_id)} : DW'(N_IN-1);
      else
        rdata_d = sel_isr ? DW'(isr_q) : DW'(irr);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      isr_q   <= '0;
      rdata_q <= '0;
    end else begin
      isr_q   <= isr_d;
      rdata_q <= rdata_d;
    end
  end

  assign bus_rdata = rdata_q;
  assign int_out   = any_req;

  a_r5_int_needs_unmasked: assert property (@(posedge clk) disable iff (!rst_n)
    int_out |-> (irr & ~imr) != '0);

  a_r6_ack_adds_one: assert property (@(posedge clk) disable iff (!rst_n)
    (poll_read && int_out && !start_pulse && !eoi_pulse)
      |=> $countones(isr_q) == $countones($past(isr_q)) + 1);

  a_r6_valid_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (poll_read && int_out) |=> bus_rdata[DW-1]);

  a_r7_spurious_code: assert property (@(posedge clk) disable iff (!rst_n)
    (poll_read && !int_out) |=> bus_rdata == DW'(N_IN-1));

  a_r7_spurious_isr_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (poll_read && !int_out && !start_pulse && !eoi_pulse) |=> $stable(isr_q));

  a_r9_eoi_drops_one: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_pulse && isr_q != '0 && !poll_read && !start_pulse)
      |=> $countones(isr_q) == $countones($past(isr_q)) - 1);
endmodule

// File: tb/test_pic_ctrl.sv
module test_pic_ctrl;
  timeunit 1ns; timeprecision 1ps;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0, bus_addr = 1'b0;
  logic [7:0] bus_wdata = 8'h00, irq_in = 8'h00;
  logic [7:0] bus_rdata, cfg_vector, cfg_cascade, cfg_mode;
  logic       int_out;

  always #4 clk = ~clk;   // 8 ns period, 125 MHz

  pic_ctrl i_pic_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_in(irq_in), .int_out(int_out), .cfg_vector(cfg_vector),
    .cfg_cascade(cfg_cascade), .cfg_mode(cfg_mode)
  );

  int n_vec = 0, n_bad = 0;
  bit done = 1'b0;

  // bench model of the requirements
  logic [7:0] m_imr, m_isr, m_irr, m_prev, m_rdata, m_vec, m_cas, m_mode;
  logic       m_poll, m_sel, m_level, m_single, m_need;
  int         m_state;   // 0 ready, 1 vector, 2 chaining, 3 mode
  string      m_rtag;

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  function automatic int lowest(input logic [7:0] v);
    for (int i = 0; i < 8; i++) if (v[i]) return i;
    return 8;
  endfunction

  function automatic logic [7:0] m_elig();
    logic [7:0] e = 8'h00;
    int lo = lowest(m_isr);
    for (int i = 0; i < 8; i++) if (m_irr[i] && !m_imr[i] && i < lo) e[i] = 1'b1;
    return e;
  endfunction

  task automatic model_reset();
    m_imr = 0; m_isr = 0; m_irr = 0; m_prev = 0; m_rdata = 0;
    m_vec = 0; m_cas = 0; m_mode = 0; m_poll = 0; m_sel = 0;
    m_level = 0; m_single = 0; m_need = 0; m_state = 0; m_rtag = "R1";
  endtask

  task automatic model_step(input bit wr, input bit rd, input bit a, input logic [7:0] d,
                            input logic [7:0] irq);
    logic [7:0] e = m_elig();
    int  pk = lowest(e);
    bit  any = (e != 0);
    bit  start = wr && !a && d[4];
    bit  selc  = wr && !a && !d[4] && d[3];
    bit  eoi   = wr && !a && !d[4] && !d[3] && d[7:5] == 3'b001;
    bit  pread = rd && !a && m_poll;
    logic [7:0] ackm = (pread && any) ? (8'h01 << pk) : 8'h00;
    logic [7:0] n_isr, n_irr;
    int lo = lowest(m_isr);
    if (rd) begin
      if (a) begin m_rdata = m_imr; m_rtag = "R4 mask read"; end
      else if (m_poll) begin
        m_rdata = any ? (8'h80 | 8'(pk)) : 8'h07;
        m_rtag = any ? "R6 poll read" : "R7 spurious poll";
      end else begin
        m_rdata = m_sel ? m_isr : m_irr; m_rtag = "R8 status read";
      end
    end
    if (start) n_isr = 0;
    else begin
      n_isr = m_isr;
      if (eoi && lo < 8) n_isr[lo] = 1'b0;
      n_isr = n_isr | ackm;
    end
    if (start) n_irr = 0;
    else if (m_level) n_irr = irq;
    else n_irr = (m_irr | (irq & ~m_prev)) & irq & ~ackm;
    if (start) begin
      m_state = 1; m_imr = 0; m_poll = 0; m_sel = 0; m_level = d[3];
      m_single = d[1]; m_need = d[0]; m_cas = 0; m_mode = 0;
    end else begin
      if (wr && a) begin
        case (m_state)
          1: begin m_vec = d; m_state = m_single ? (m_need ? 3 : 0) : 2; end
          2: begin m_cas = d; m_state = m_need ? 3 : 0; end
          3: begin m_mode = d; m_state = 0; end
          default: m_imr = d;
        endcase
      end
      if (selc) begin
        m_poll = d[2];
        if (d[1]) m_sel = d[0];
      end else if (rd && !a) m_poll = 0;
    end
    m_isr = n_isr; m_irr = n_irr; m_prev = irq;
  endtask

  task automatic cyc(input bit wr, input bit rd, input bit a, input logic [7:0] d);
    bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    model_step(wr, rd, a, d, irq_in);
    @(negedge clk);
    bus_wr = 0; bus_rd = 0;
    chk("R5 int_out", {7'd0, int_out}, {7'd0, m_elig() != 0});
    if (rd) chk(m_rtag, bus_rdata, m_rdata);
    chk("R2 cfg_vector", cfg_vector, m_vec);
    chk("R3 cfg_cascade", cfg_cascade, m_cas);
    chk("R2 cfg_mode", cfg_mode, m_mode);
  endtask

  task automatic idle();             cyc(0, 0, 0, 8'h00); endtask
  task automatic wr_even(input logic [7:0] d); cyc(1, 0, 0, d); endtask
  task automatic wr_odd(input logic [7:0] d);  cyc(1, 0, 1, d); endtask
  task automatic rd_even();          cyc(0, 1, 0, 8'h00); endtask
  task automatic rd_odd();           cyc(0, 1, 1, 8'h00); endtask
  task automatic poll();             wr_even(8'h0C); rd_even(); endtask

  task automatic setup(input logic [7:0] s, input logic [7:0] v, input logic [7:0] c);
    wr_even(s); wr_odd(v); wr_odd(c); wr_odd(8'h01); wr_odd(8'h00);
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 int_out", {7'd0, int_out}, 8'h00);
    chk("R1 rdata", bus_rdata, 8'h00);
    chk("R1 cfg", cfg_vector | cfg_cascade | cfg_mode, 8'h00);
    rd_odd();  chk("R1 mask after reset", bus_rdata, 8'h00);
    rd_even(); chk("R1 request after reset", bus_rdata, 8'h00);

    // R2/R3 master setup, chaining mask on line 2
    wr_even(8'h11); wr_odd(8'h20); wr_odd(8'h04); wr_odd(8'h01);
    chk("R2 vector word", cfg_vector, 8'h20);
    chk("R3 master chaining word", cfg_cascade, 8'h04);
    chk("R2 mode word", cfg_mode, 8'h01);
    wr_odd(8'hF0); rd_odd(); chk("R4 mask readback", bus_rdata, 8'hF0);
    irq_in = 8'h10; idle(); chk("R4 masked line quiet", {7'd0, int_out}, 8'h00);
    irq_in = 8'h00; wr_odd(8'h00); idle();

    // R10 edge mode: no new request while line stays high
    irq_in = 8'h08; idle(); chk("R5 int raised", {7'd0, int_out}, 8'h01);
    poll(); chk("R6 poll line 3", bus_rdata, 8'h83);
    wr_even(8'h20); idle(); chk("R10 held line no rerequest", {7'd0, int_out}, 8'h00);
    irq_in = 8'h00; idle(); irq_in = 8'h08; idle();
    chk("R10 new edge requests", {7'd0, int_out}, 8'h01);
    poll(); wr_even(8'h20); irq_in = 8'h00; idle();

    // R7 withdrawn request
    irq_in = 8'h20; idle(); irq_in = 8'h00; idle();
    poll(); chk("R7 spurious code", bus_rdata, 8'h07);
    wr_even(8'h0B); rd_even(); chk("R7 in-service bit 7 clear", bus_rdata, 8'h00);

    // R9 nested service and EOI order
    irq_in = 8'h10; idle(); poll(); chk("R6 poll line 4", bus_rdata, 8'h84);
    irq_in = 8'h12; idle(); poll(); chk("R6 nested line 1", bus_rdata, 8'h81);
    rd_even(); chk("R8 in-service kept after poll", bus_rdata, 8'h12);
    wr_even(8'h20); rd_even(); chk("R9 first EOI", bus_rdata, 8'h10);
    wr_even(8'h20); rd_even(); chk("R9 second EOI", bus_rdata, 8'h00);
    wr_even(8'h20); rd_even(); chk("R9 EOI with none", bus_rdata, 8'h00);

    // same cycle: poll acknowledge and EOI
    irq_in = 8'h00; idle(); irq_in = 8'h10; idle(); poll();
    irq_in = 8'h12; idle(); wr_even(8'h0C);
    cyc(1, 1, 0, 8'h20); chk("R6 poll with EOI", bus_rdata, 8'h81);
    rd_even(); chk("R9 EOI beside ack", bus_rdata, 8'h02);
    wr_even(8'h20); irq_in = 8'h00; idle();
    wr_even(8'h0A); irq_in = 8'h40; idle(); rd_even();
    chk("R8 request select", bus_rdata, 8'h40);
    irq_in = 8'h00; idle();

    // R11 level mode, slave chaining number
    wr_even(8'h19); wr_odd(8'h28); wr_odd(8'h02); wr_odd(8'h01);
    chk("R3 slave number", cfg_cascade, 8'h02);
    irq_in = 8'h40; idle(); idle(); poll(); chk("R11 level poll", bus_rdata, 8'h86);
    wr_even(8'h20); idle(); chk("R11 rerequest", {7'd0, int_out}, 8'h01);
    poll(); chk("R11 second ack", bus_rdata, 8'h86);
    irq_in = 8'h00; wr_even(8'h20); idle(); chk("R11 line low", {7'd0, int_out}, 8'h00);

    // R2 shortened sequences
    wr_even(8'h13); wr_odd(8'h30); wr_odd(8'h05);
    chk("R2 single skips chaining", cfg_cascade, 8'h00);
    chk("R2 single mode word", cfg_mode, 8'h05);
    wr_even(8'h12); wr_odd(8'h40); wr_odd(8'hAA); rd_odd();
    chk("R2 no mode word then mask", bus_rdata, 8'hAA);

    // random phase
    setup(8'h11, 8'h00, 8'h04);
    for (int n = 0; n < 4000; n++) begin
      int op = $urandom % 16;
      if (n == 2000) setup(8'h19, 8'h08, 8'h02);
      if ($urandom % 4 == 0) irq_in = irq_in ^ (8'h01 << ($urandom % 8));
      case (op)
        6:  wr_odd(8'($urandom) & 8'($urandom));
        7:  rd_odd();
        8:  wr_even(8'h0C);
        9, 15: rd_even();
        10: wr_even(8'h20);
        11: wr_even(8'h0B);
        12: wr_even(8'h0A);
        13: cyc(1, 1, 0, 8'h20);
        14: wr_even(8'h0E);
        default: idle();
      endcase
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule